// File: doc/BRIEF.md
# Keyed Watchdog Timer with NMI Escalation

This block is a watchdog counter that starts running as soon as hardware reset is released. Software reaches it through one 16-bit control register on a simple register bus, with write and read strobes. Two things are protected by two-word key sequences written to that register. One sequence opens a single configuration write. The other restarts the count. Software that has lost control is therefore unlikely to hold off the watchdog by accident.

When the count reaches the selected period, the block does one of two things. In interrupt mode it raises a one-cycle non-maskable interrupt pulse and sets an interrupt flag. In reset mode it raises a one-cycle system reset request. A second expiry while the interrupt flag is still set escalates to a reset request. A reset flag records that the watchdog caused the last reset, and it stays set through that reset. The configuration also stays through a watchdog reset, while the counter, the key state, the interrupt flag and the write-once lock return to their starting values. Only the hardware reset clears everything.

Top module: `keyed_wdt`

## Requirements
- R1: After hardware reset the register reads 16'h8007. That means enable (bit 15) is 1, mode (bit 3, 1 = interrupt, 0 = reset) is 0, period exponent (bits 2:0) is 7, reset flag (bit 13) is 0 and interrupt flag (bit 12) is 0. All other bits read 0.
- R2: With exponent N, the timeout output rises exactly 2^(BASE_EXP+N) clock edges after the edge that restarted the count. Hardware reset release, a completed restart key and a configuration write each count as a restart.
- R3: A configuration write is taken only as the write that directly follows 16'h3333 and then 16'hCCCC. Idle bus cycles may occur between these writes.
- R4: Enable, mode and exponent are taken from the first configuration write only. Later configuration writes leave them unchanged until a hardware or watchdog reset.
- R5: Writing 16'hAAAA and then 16'h5555 restarts the count. The count value never appears in the read data.
- R6: A read of the register, or a write of any other value, between the two words of a key aborts the sequence, and the second word then has no effect. A lone second word also has no effect.
- R7: In reset mode an expiry drives sys_rst_req high for exactly one cycle and sets the reset flag.
- R8: In interrupt mode an expiry drives nmi_pulse high for exactly one cycle and sets the interrupt flag.
- R9: An expiry while the interrupt flag is set gives a one-cycle sys_rst_req instead of a second nmi_pulse.
- R10: Any register read or write clears the reset flag. A watchdog reset keeps the configuration and the reset flag, clears the interrupt flag, and reopens the write-once lock.
- R11: A configuration write with bit 12 at 0 clears the interrupt flag, even after the lock is set. With bit 12 at 1 the flag is left as it is.
- R12: With enable at 0, no timeout output is ever produced.
- R13: Every configuration write, whether or not the lock lets it through, restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, synchronous, active low |
| wdt_wr | input | 1 | Write strobe for the control register |
| wdt_rd | input | 1 | Read strobe for the control register |
| wdt_wdata | input | 16 | Write data |
| wdt_rdata | output | 16 | Register contents, always valid |
| nmi_pulse | output | 1 | One-cycle non-maskable interrupt |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
The hardest state to reach from the ports is an expiry while the interrupt flag is still set. Getting there requires an unlocked configuration write that selects interrupt mode, then a first expiry, and then no clearing write before the next full period. The bench runs with a tiny base exponent, so every period is a few cycles. It sweeps all eight exponents in both modes, each starting from hardware reset, and lets each interrupt-mode run go on to the escalated reset. It then reads back that the interrupt flag is clear and that the configuration and the reset flag have survived.

// File: rtl/wdt_pkg.sv
// Shared constants and types for the keyed watchdog.
// Assumes a 16-bit control register; key words and flag positions are fixed.
package wdt_pkg;
    localparam int REG_W = 16;
    localparam int EXP_W = 3;

    localparam logic [REG_W-1:0] KEY_CFG_A  = 16'h3333;
    localparam logic [REG_W-1:0] KEY_CFG_B  = 16'hCCCC;
    localparam logic [REG_W-1:0] KEY_KICK_A = 16'hAAAA;
    localparam logic [REG_W-1:0] KEY_KICK_B = 16'h5555;

    localparam int BIT_EN   = 15;
    localparam int BIT_RSTF = 13;
    localparam int BIT_NMIF = 12;
    localparam int BIT_MODE = 3;

    typedef enum logic [1:0] {
        KS_IDLE,
        KS_CFG_HALF,
        KS_CFG_OPEN,
        KS_KICK_HALF
    } key_state_e;

    typedef struct packed {
        logic             enable;
        logic             nmi_mode;
        logic [EXP_W-1:0] exp_sel;
    } wdt_cfg_t;
endpackage

// File: rtl/wdt_keyseq.sv
// Key sequence tracker: decodes register accesses into a configuration
// data strobe and a count restart strobe.
// Assumes at most one access per cycle; a read of the register aborts.
module wdt_keyseq
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wd_clear,
    input  logic             acc_wr,
    input  logic             acc_rd,
    input  logic [REG_W-1:0] acc_wdata,
    output logic             data_stb,
    output logic             kick_stb
);
    key_state_e state_q, state_d;

    function automatic key_state_e start_of(input logic [REG_W-1:0] d);
        if (d == KEY_CFG_A)       return KS_CFG_HALF;
        else if (d == KEY_KICK_A) return KS_KICK_HALF;
        else                      return KS_IDLE;
    endfunction

    // Next-state and strobe decode for one register access.
    always_comb begin
        state_d  = state_q;
        data_stb = 1'b0;
        kick_stb = 1'b0;
        if (acc_wr) begin
            unique case (state_q)
                KS_CFG_OPEN: begin
                    data_stb = 1'b1;
                    state_d  = KS_IDLE;
                end
                KS_CFG_HALF:
                    state_d = (acc_wdata == KEY_CFG_B) ? KS_CFG_OPEN : start_of(acc_wdata);
                KS_KICK_HALF: begin
                    if (acc_wdata == KEY_KICK_B) begin
                        kick_stb = 1'b1;
                        state_d  = KS_IDLE;
                    end else begin
                        state_d = start_of(acc_wdata);
                    end
                end
                default: state_d = start_of(acc_wdata);
            endcase
        end else if (acc_rd) begin
            state_d = KS_IDLE;
        end
    end

    // Key state register, cleared by hardware and watchdog reset.
    always_ff @(posedge clk) begin
        if (!rst_n || wd_clear) state_q <= KS_IDLE;
        else                    state_q <= state_d;
    end

    // A lone read leaves no half-finished restart key behind.
    assert_read_aborts_kick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd && !acc_wr) |=> !kick_stb);
endmodule

// File: rtl/wdt_timebase.sv
// Watchdog counter: counts enabled cycles and flags expiry at 2^(BASE_EXP+N).
// Assumes the exponent only changes together with a restart.
module wdt_timebase
    import wdt_pkg::*;
#(
    parameter int BASE_EXP = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [EXP_W-1:0] exp_sel,
    input  logic             restart,
    output logic             expire
);
    localparam int CNT_W = BASE_EXP + (1 << EXP_W) - 1;
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_val;

    // Terminal count for the selected exponent.
    always_comb last_val = (ONE << (BASE_EXP + 32'(exp_sel))) - ONE;

    // Expiry fires on the terminal count unless a restart takes priority.
    always_comb expire = enable && !restart && (cnt_q == last_val);

    // Count register, zeroed on restart, expiry or while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || expire || !enable) cnt_q <= '0;
        else                                       cnt_q <= cnt_q + ONE;
    end

    assert_cnt_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= last_val);
    assert_idle_when_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (cnt_q == '0));
endmodule

// File: rtl/wdt_ctrl.sv
// Configuration, flags and timeout outputs. Hardware reset clears all;
// a watchdog reset keeps configuration and reset flag.
// Assumes data strobe and expiry never coincide (restart wins in timebase).
module wdt_ctrl
    import wdt_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     acc_any,
    input  logic     data_stb,
    input  wdt_cfg_t cfg_in,
    input  logic     keep_nmif,
    input  logic     expire,
    output wdt_cfg_t cfg_q,
    output logic     nmi_flag_q,
    output logic     rst_flag_q,
    output logic     wd_clear,
    output logic     nmi_pulse,
    output logic     sys_rst_req
);
    logic lock_q;
    logic nmi_hit;

    // Decide whether an expiry interrupts or resets.
    always_comb begin
        wd_clear = expire && (!cfg_q.nmi_mode || nmi_flag_q);
        nmi_hit  = expire && cfg_q.nmi_mode && !nmi_flag_q;
    end

    // Write-once configuration and its lock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= '{enable: 1'b1, nmi_mode: 1'b0, exp_sel: '1};
            lock_q <= 1'b0;
        end else if (wd_clear) begin
            lock_q <= 1'b0;
        end else if (data_stb && !lock_q) begin
            cfg_q  <= cfg_in;
            lock_q <= 1'b1;
        end
    end

    // Interrupt flag: set on first expiry, cleared by config data or watchdog reset.
    always_ff @(posedge clk) begin
        if (!rst_n || wd_clear)          nmi_flag_q <= 1'b0;
        else if (nmi_hit)                nmi_flag_q <= 1'b1;
        else if (data_stb && !keep_nmif) nmi_flag_q <= 1'b0;
    end

    // Reset flag: set by watchdog reset, cleared by any register access.
    always_ff @(posedge clk) begin
        if (!rst_n)       rst_flag_q <= 1'b0;
        else if (wd_clear) rst_flag_q <= 1'b1;
        else if (acc_any)  rst_flag_q <= 1'b0;
    end

    // One-cycle timeout outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_pulse   <= 1'b0;
            sys_rst_req <= 1'b0;
        end else begin
            nmi_pulse   <= nmi_hit;
            sys_rst_req <= wd_clear;
        end
    end

    assert_pulses_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(nmi_pulse && sys_rst_req));
    assert_escalate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && nmi_flag_q) |=> sys_rst_req);
    assert_rst_flag_on_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |-> rst_flag_q);
    assert_single_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |=> !sys_rst_req);
    assert_nmi_flag_on_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_pulse |-> nmi_flag_q);
    assert_write_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (data_stb && lock_q) |=> $stable(cfg_q));
    assert_flag_access_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_any && !wd_clear) |=> !rst_flag_q);
endmodule

// File: rtl/keyed_wdt.sv
// Keyed watchdog top: wires key decode, counter and control, and forms
// the read view of the control register (count never visible).
// Assumes a single-cycle register bus with separate write and read strobes.
module keyed_wdt
    import wdt_pkg::*;
#(
    parameter int BASE_EXP = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wdt_wr,
    input  logic             wdt_rd,
    input  logic [REG_W-1:0] wdt_wdata,
    output logic [REG_W-1:0] wdt_rdata,
    output logic             nmi_pulse,
    output logic             sys_rst_req
);
    logic     data_stb, kick_stb, expire, wd_clear;
    logic     nmi_flag, rst_flag;
    wdt_cfg_t cfg, cfg_in;

    // Unpack configuration fields from the write data.
    always_comb begin
        cfg_in.enable   = wdt_wdata[BIT_EN];
        cfg_in.nmi_mode = wdt_wdata[BIT_MODE];
        cfg_in.exp_sel  = wdt_wdata[EXP_W-1:0];
    end

    wdt_keyseq u_keyseq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wd_clear (wd_clear),
        .acc_wr   (wdt_wr),
        .acc_rd   (wdt_rd),
        .acc_wdata(wdt_wdata),
        .data_stb (data_stb),
        .kick_stb (kick_stb)
    );

    wdt_timebase #(.BASE_EXP(BASE_EXP)) u_timebase (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (cfg.enable),
        .exp_sel(cfg.exp_sel),
        .restart(kick_stb || data_stb),
        .expire (expire)
    );

    wdt_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_any    (wdt_wr || wdt_rd),
        .data_stb   (data_stb),
        .cfg_in     (cfg_in),
        .keep_nmif  (wdt_wdata[BIT_NMIF]),
        .expire     (expire),
        .cfg_q      (cfg),
        .nmi_flag_q (nmi_flag),
        .rst_flag_q (rst_flag),
        .wd_clear   (wd_clear),
        .nmi_pulse  (nmi_pulse),
        .sys_rst_req(sys_rst_req)
    );

    // Register read view.
    always_comb begin
        wdt_rdata                = '0;
        wdt_rdata[BIT_EN]        = cfg.enable;
        wdt_rdata[BIT_RSTF]      = rst_flag;
        wdt_rdata[BIT_NMIF]      = nmi_flag;
        wdt_rdata[BIT_MODE]      = cfg.nmi_mode;
        wdt_rdata[EXP_W-1:0]     = cfg.exp_sel;
    end
endmodule

// File: tb/keyed_wdt_tb.sv
`timescale 1ns/1ps
module keyed_wdt_tb;
    localparam int B = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        nmi, srst;

    int checks = 0, errors = 0, cyc = 0, n_nmi = 0, n_rst = 0;

    keyed_wdt #(.BASE_EXP(B)) u_dut (
        .clk(clk), .rst_n(rst_n), .wdt_wr(wr), .wdt_rd(rd), .wdt_wdata(wdata),
        .wdt_rdata(rdata), .nmi_pulse(nmi), .sys_rst_req(srst)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) begin
        if (nmi)  n_nmi <= n_nmi + 1;
        if (srst) n_rst <= n_rst + 1;
    end

    function automatic logic [15:0] cfgw(input bit en, input bit m, input bit keep, input int n);
        return {en, 2'b00, keep, 8'h00, m, 3'(n)};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hw_reset(output int t0);
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1; t0 = cyc;
    endtask

    task automatic do_wr(input logic [15:0] d);
        @(negedge clk); wr = 1'b1; wdata = d;
        @(posedge clk); #1; wr = 1'b0;
    endtask

    task automatic do_rd(output logic [15:0] d);
        @(negedge clk); rd = 1'b1; #1 d = rdata;
        @(posedge clk); #1; rd = 1'b0;
    endtask

    task automatic config_wr(input logic [15:0] d, output int t0);
        do_wr(16'h3333); do_wr(16'hCCCC); do_wr(d); t0 = cyc;
    endtask

    // kind: 0 none, 1 interrupt, 2 reset; at = cycle of the edge that raised it
    task automatic wait_evt(input int lim, output int kind, output int at);
        kind = 0; at = 0;
        for (int i = 0; i < lim && kind == 0; i++) begin
            @(negedge clk);
            if (nmi)       begin kind = 1; at = cyc; end
            else if (srst) begin kind = 2; at = cyc; end
        end
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int t0, t1, t2, k;
        logic [15:0] r, r2;

        // R1 reset state, then default period in reset mode (R2, R7)
        hw_reset(t0);
        @(negedge clk);
        chk("R1 reset rdata", rdata, 16'h8007);
        chk("R1 no outputs", {nmi, srst}, 0);
        wait_evt(2000, k, t1);
        chk("R7 default kind", k, 2);
        chk("R2 default period", t1 - t0, 1 << (B + 7));
        @(negedge clk);
        chk("R7 one-cycle req", srst, 0);
        do_rd(r);
        chk("R10 rst flag survives", r, 16'hA007);
        do_rd(r);
        chk("R10 read clears rst flag", r, 16'h8007);

        // Sweep all exponents in both modes (R2, R7, R8, R9, R10)
        for (int n = 0; n < 8; n++) begin
            for (int m = 0; m < 2; m++) begin
                hw_reset(t0);
                config_wr(cfgw(1, m[0], 0, n), t0);
                wait_evt(2000, k, t1);
                chk("R2 period", t1 - t0, 1 << (B + n));
                chk(m ? "R8 kind" : "R7 kind", k, m ? 1 : 2);
                @(negedge clk);
                chk("R8/R7 pulse width", {nmi, srst}, 0);
                if (m == 1) begin
                    wait_evt(2000, k, t2);
                    chk("R9 escalation kind", k, 2);
                    chk("R9 escalation period", t2 - t1, 1 << (B + n));
                    @(negedge clk);
                    do_rd(r);
                    chk("R10 after escalation", r, 16'hA008 | n);
                end else begin
                    do_rd(r);
                    chk("R10 after reset timeout", r, 16'hA000 | n);
                end
            end
        end

        // R4 write once
        hw_reset(t0);
        config_wr(cfgw(1, 1, 0, 1), t0);
        config_wr(cfgw(1, 0, 0, 5), t0);
        do_rd(r);
        chk("R4 second config ignored", r, 16'h8009);

        // R10 watchdog reset reopens lock, write clears rst flag
        hw_reset(t0);
        config_wr(cfgw(1, 0, 0, 1), t0);
        wait_evt(2000, k, t1);
        chk("R7 kind N1", k, 2);
        config_wr(cfgw(1, 1, 0, 2), t0);
        do_rd(r);
        chk("R10 lock reopened", r, 16'h800A);
        wait_evt(2000, k, t1);
        chk("R8 after relock kind", k, 1);
        chk("R13 period from config", t1 - t0, 1 << (B + 2));

        // R5 restart key with idle gap, count not readable
        hw_reset(t0);
        config_wr(cfgw(1, 0, 0, 3), t0);
        do_rd(r);
        repeat (8) @(posedge clk);
        do_rd(r2);
        chk("R5 count not visible", r2, r);
        do_wr(16'hAAAA);
        repeat (3) @(posedge clk);
        do_wr(16'h5555); t0 = cyc;
        wait_evt(2000, k, t1);
        chk("R5 restart period", t1 - t0, 32);

        // R6 broken restart sequences do not restart
        for (int v = 0; v < 4; v++) begin
            hw_reset(t0);
            config_wr(cfgw(1, 0, 0, 3), t0);
            repeat (2) @(posedge clk);
            case (v)
                0: begin do_wr(16'hAAAA); do_rd(r); do_wr(16'h5555); end
                1: begin do_wr(16'hAAAA); do_wr(16'h1234); do_wr(16'h5555); end
                2: begin do_wr(16'h5555); end
                default: begin do_wr(16'hAAAA); do_wr(16'h3333); do_wr(16'h5555); end
            endcase
            wait_evt(2000, k, t1);
            chk("R6 aborted restart", t1 - t0, 32);
        end

        // R3 / R6 configuration key
        hw_reset(t0);
        do_wr(16'h3333); do_rd(r); do_wr(16'hCCCC); do_wr(cfgw(1, 1, 0, 2));
        do_rd(r);
        chk("R6 read aborts config key", r, 16'h8007);
        do_wr(16'h3333); do_wr(16'h1234); do_wr(16'hCCCC); do_wr(cfgw(1, 1, 0, 2));
        do_rd(r);
        chk("R6 stray write aborts config key", r, 16'h8007);
        do_wr(16'h3333); do_wr(16'hCCCC);
        repeat (3) @(posedge clk);
        do_wr(cfgw(1, 1, 0, 2));
        do_rd(r);
        chk("R3 config after key with idle", r, 16'h800A);

        // R11 interrupt flag clear through locked config write
        hw_reset(t0);
        config_wr(cfgw(1, 1, 0, 2), t0);
        wait_evt(2000, k, t1);
        chk("R8 kind", k, 1);
        do_rd(r);
        chk("R8 flag set", r, 16'h900A);
        config_wr(cfgw(1, 0, 1, 5), t0);
        do_rd(r);
        chk("R11 keep flag, R4 fields locked", r, 16'h900A);
        config_wr(cfgw(1, 1, 0, 2), t0);
        do_rd(r);
        chk("R11 flag cleared", r, 16'h800A);
        wait_evt(2000, k, t1);
        chk("R11 next is interrupt", k, 1);
        chk("R13 locked write restarts", t1 - t0, 16);

        // R12 disabled
        hw_reset(t0);
        config_wr(cfgw(0, 0, 0, 0), t0);
        t1 = n_nmi + n_rst;
        repeat (2500) @(posedge clk);
        @(negedge clk);
        chk("R12 no timeouts when disabled", n_nmi + n_rst, t1);
        do_rd(r);
        chk("R12 rdata disabled", r, 16'h0000);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule